// File: doc/BRIEF.md
# Time-Slot Bus Arbiter with Round-Robin Slot Reclaim

This block decides which of several bus masters drives a shared bus. Time is cut into a repeating frame of slots, each a fixed number of clock cycles long. A programmable table names one owning master per slot. A master with a larger bandwidth budget simply owns more entries. When a slot begins and its owner is requesting, the owner receives the grant. When the owner is idle, a round-robin search over the other requesters hands the slot to someone else, so the slot is not wasted.

A grant lasts until the end of its slot, even if the winner lowers its request early; the bus then sits idle for the rest of that slot. If nobody holds the bus during a slot, a request that arrives partway through is decided at once by the same rules. Table entries, slot length and frame length are written through a small programming port. They are staged and take effect together at the next frame start, so a frame never mixes old and new settings. The grant follows the request inputs combinationally in the decision cycle and is held in a register after that.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: After reset the frame starts at slot 0 on its first cycle, slot i is owned by master i modulo the master count, each slot lasts SLOT_LAST_DEF+1 cycles, the frame has 2^SLOT_W slots, and the round-robin pointer is 0. While reset is held with no request, grant is zero.
- R2: In the first cycle of a slot, if the master named by that slot's active table entry is requesting, grant is the one-hot vector with only that master's bit set.
- R3: In the first cycle of a slot with the owner idle, the grant goes to the first requesting master found by searching upward from the round-robin pointer, wrapping past the highest index. After such a fallback grant the pointer becomes one past the winner, wrapping to 0. Owner grants leave the pointer unchanged.
- R4: A slot lasts cfgSlotLast+1 cycles and a frame holds cfgFrameLast+1 slots. After the last slot of a frame the slot index returns to 0.
- R5: Writes to the table (tblWrEn with tblWrIdx and tblWrOwner) and to the frame settings (cfgWrEn) have no effect on grants until the first cycle after the frame in progress ends. A write in the last cycle of a frame waits one more frame.
- R6: grant has at most one bit set, and it is zero only when req is zero.
- R7: Once a master holds the grant, the grant stays unchanged until the last cycle of the slot, whatever its request does.
- R8: If no master holds the grant partway through a slot, a new request is granted in the same cycle under the rules of R2 and R3.
- R9: With every master owning at least one slot, a master that keeps its request high is granted within two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 2^MID_W | One request line per master |
| grant | output | 2^MID_W | One grant line per master, at most one high |
| tblWrEn | input | 1 | Stage a slot table entry write |
| tblWrIdx | input | SLOT_W | Slot entry being written |
| tblWrOwner | input | MID_W | Master that will own that slot |
| cfgWrEn | input | 1 | Stage a new slot length and frame length |
| cfgSlotLast | input | LEN_W | Slot length in cycles, minus one |
| cfgFrameLast | input | SLOT_W | Slots per frame, minus one |

## Verification
The bench goes after the owner-idle fallback across pointer wrap. A design that restarted the search at master 0, or moved the pointer on owner grants, would hand slots to the wrong master. It also targets requests that drop inside a held slot and requests that arrive in a slot nobody holds. A design that freed the bus early or waited for the next slot boundary would show a changed or missing grant. Table and frame-setting writes are issued mid-frame, including on the last cycle of a frame. A design that applied them at once would change owners or slot boundaries one frame early. One master is also held requesting under random contention, to catch a fallback that starves it.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  // Timing strobes sent from the frame control to the grant datapath.
  typedef struct packed {
    logic slotStart;  // first cycle of a slot
    logic slotEnd;    // last cycle of a slot
    logic frameEnd;   // last cycle of the last slot of the frame
  } tdma_strobe_t;
endpackage

// File: rtl/tdma_frame_ctrl.sv
module tdma_frame_ctrl
  import tdma_pkg::*;
#(
  parameter int SLOT_W        = 3,
  parameter int LEN_W         = 8,
  parameter int SLOT_LAST_DEF = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [LEN_W-1:0]  cfgSlotLast,
  input  logic [SLOT_W-1:0] cfgFrameLast,
  output logic [SLOT_W-1:0] slotIdx,
  output tdma_strobe_t      strb
);
  localparam logic [SLOT_W-1:0] FRAME_LAST_DEF = '1;
  localparam logic [LEN_W-1:0]  SLOT_LAST_RST  = LEN_W'(SLOT_LAST_DEF);

  logic [LEN_W-1:0]  cycCnt;
  logic [LEN_W-1:0]  pendSlotLast, actSlotLast;
  logic [SLOT_W-1:0] pendFrameLast, actFrameLast;

  always_comb begin
    strb.slotStart = (cycCnt == '0);
    strb.slotEnd   = (cycCnt == actSlotLast);
    strb.frameEnd  = strb.slotEnd && (slotIdx == actFrameLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt        <= '0;
      slotIdx       <= '0;
      pendSlotLast  <= SLOT_LAST_RST;
      actSlotLast   <= SLOT_LAST_RST;
      pendFrameLast <= FRAME_LAST_DEF;
      actFrameLast  <= FRAME_LAST_DEF;
    end else begin
      if (cfgWrEn) begin
        pendSlotLast  <= cfgSlotLast;
        pendFrameLast <= cfgFrameLast;
      end
      if (strb.slotEnd) begin
        cycCnt <= '0;
        if (strb.frameEnd) begin
          slotIdx      <= '0;
          actSlotLast  <= pendSlotLast;
          actFrameLast <= pendFrameLast;
        end else begin
          slotIdx <= slotIdx + SLOT_W'(1);
        end
      end else begin
        cycCnt <= cycCnt + LEN_W'(1);
      end
    end
  end

  // R4: the cycle counter never passes the active slot length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cycCnt <= actSlotLast);
  // R4: slot index moves only at a slot boundary, by one
  a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slotEnd |=> slotIdx == $past(slotIdx));
  a_r4_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slotEnd && !strb.frameEnd) |=> slotIdx == $past(slotIdx) + SLOT_W'(1));
  // R4: a frame wraps back to slot 0 on a fresh slot
  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |=> (slotIdx == '0) && strb.slotStart);
  // R5: active frame settings change only at a frame boundary
  a_r5_cfg_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameEnd |=> $stable(actSlotLast) && $stable(actFrameLast));
endmodule

// File: rtl/tdma_grant_dp.sv
module tdma_grant_dp
  import tdma_pkg::*;
#(
  parameter int MID_W  = 2,
  parameter int SLOT_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [(1<<MID_W)-1:0]   req,
  input  tdma_strobe_t            strb,
  input  logic [SLOT_W-1:0]       slotIdx,
  input  logic                    tblWrEn,
  input  logic [SLOT_W-1:0]       tblWrIdx,
  input  logic [MID_W-1:0]        tblWrOwner,
  output logic [(1<<MID_W)-1:0]   grant
);
  localparam int NM    = 1 << MID_W;
  localparam int SLOTS = 1 << SLOT_W;

  logic [MID_W-1:0] pendTbl [SLOTS];
  logic [MID_W-1:0] actTbl  [SLOTS];
  logic [NM-1:0]    heldGrant, pickVec;
  logic [MID_W-1:0] owner, rrPtr, rrIdx;
  logic             ownerReq, rrHit, decide, fallbackWin;

  assign owner    = actTbl[slotIdx];
  assign ownerReq = req[owner];
  assign decide   = strb.slotStart || (heldGrant == '0);

  // Second level: first requester at or above the pointer, wrapping.
  always_comb begin
    rrHit = 1'b0;
    rrIdx = rrPtr;
    for (int k = 0; k < NM; k++) begin
      if (!rrHit && req[rrPtr + MID_W'(k)]) begin
        rrHit = 1'b1;
        rrIdx = rrPtr + MID_W'(k);
      end
    end
  end

  always_comb begin
    if (ownerReq)   pickVec = NM'(1) << owner;
    else if (rrHit) pickVec = NM'(1) << rrIdx;
    else            pickVec = '0;
  end

  assign fallbackWin = decide && !ownerReq && rrHit;
  assign grant       = decide ? pickVec : heldGrant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldGrant <= '0;
      rrPtr     <= '0;
    end else begin
      heldGrant <= grant;
      if (fallbackWin) rrPtr <= rrIdx + MID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        pendTbl[i] <= MID_W'(i);
        actTbl[i]  <= MID_W'(i);
      end
    end else begin
      if (strb.frameEnd) begin
        for (int i = 0; i < SLOTS; i++) actTbl[i] <= pendTbl[i];
      end
      if (tblWrEn) pendTbl[tblWrIdx] <= tblWrOwner;
    end
  end

  // R6: never two masters on the bus
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R6: an empty grant means nobody asked
  a_r6_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0) |-> (req == '0));
  // R2: a requesting owner takes its slot
  a_r2_owner_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.slotStart && req[actTbl[slotIdx]]) |-> grant[actTbl[slotIdx]]);
  // R7: a held grant survives to the slot boundary
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((grant != '0) && !strb.slotEnd) |=> grant == $past(grant));
  // R3: pointer moves one past a fallback winner, otherwise stays
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    fallbackWin |=> rrPtr == $past(rrIdx) + MID_W'(1));
  a_r3_ptr_keep: assert property (@(posedge clk) disable iff (!rstN)
    !fallbackWin |=> $stable(rrPtr));
  // R5: the slot owner is fixed for the whole slot
  a_r5_owner_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slotEnd |=> $stable(owner));
endmodule

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter
  import tdma_pkg::*;
#(
  parameter int MID_W         = 2,
  parameter int SLOT_W        = 3,
  parameter int LEN_W         = 8,
  parameter int SLOT_LAST_DEF = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [(1<<MID_W)-1:0] req,
  output logic [(1<<MID_W)-1:0] grant,
  input  logic                  tblWrEn,
  input  logic [SLOT_W-1:0]     tblWrIdx,
  input  logic [MID_W-1:0]      tblWrOwner,
  input  logic                  cfgWrEn,
  input  logic [LEN_W-1:0]      cfgSlotLast,
  input  logic [SLOT_W-1:0]     cfgFrameLast
);
  tdma_strobe_t      strb;
  logic [SLOT_W-1:0] slotIdx;

  tdma_frame_ctrl #(
    .SLOT_W(SLOT_W), .LEN_W(LEN_W), .SLOT_LAST_DEF(SLOT_LAST_DEF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSlotLast(cfgSlotLast),
    .cfgFrameLast(cfgFrameLast), .slotIdx(slotIdx), .strb(strb)
  );

  tdma_grant_dp #(
    .MID_W(MID_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .req(req), .strb(strb), .slotIdx(slotIdx),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrOwner(tblWrOwner),
    .grant(grant)
  );
endmodule

// File: tb/tdma_rr_arbiter_tb.sv
module tdma_rr_arbiter_tb;
  localparam int CLK_PERIOD    = 10;
  localparam int MID_W         = 2;
  localparam int SLOT_W        = 3;
  localparam int LEN_W         = 8;
  localparam int SLOT_LAST_DEF = 3;
  localparam int NM            = 1 << MID_W;
  localparam int SLOTS         = 1 << SLOT_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NM-1:0]     req = '0;
  logic [NM-1:0]     grant;
  logic              tblWrEn = 1'b0;
  logic [SLOT_W-1:0] tblWrIdx = '0;
  logic [MID_W-1:0]  tblWrOwner = '0;
  logic              cfgWrEn = 1'b0;
  logic [LEN_W-1:0]  cfgSlotLast = '0;
  logic [SLOT_W-1:0] cfgFrameLast = '0;

  tdma_rr_arbiter #(
    .MID_W(MID_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W), .SLOT_LAST_DEF(SLOT_LAST_DEF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .req(req), .grant(grant),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrOwner(tblWrOwner),
    .cfgWrEn(cfgWrEn), .cfgSlotLast(cfgSlotLast), .cfgFrameLast(cfgFrameLast)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference state, kept from the requirements
  int mCyc, mSlot, mRr, mWin;
  int mActSL, mActFL, mPendSL, mPendFL;
  int mAct [SLOTS];
  int mPend [SLOTS];
  logic [NM-1:0] mHeld, mExp;
  bit mDecide, mFallback;
  string mWhy;
  int waitCnt, maxWait;

  task automatic check(input logic [NM-1:0] act, input logic [NM-1:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: grant=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCyc = 0; mSlot = 0; mRr = 0; mHeld = '0;
    mActSL = SLOT_LAST_DEF; mPendSL = SLOT_LAST_DEF;
    mActFL = SLOTS - 1;     mPendFL = SLOTS - 1;
    for (int i = 0; i < SLOTS; i++) begin
      mAct[i]  = i % NM;
      mPend[i] = i % NM;
    end
  endtask

  task automatic computeExp(input logic [NM-1:0] r);
    int own;
    own = mAct[mSlot];
    mDecide = (mCyc == 0) || (mHeld == '0);
    mFallback = 1'b0;
    if (!mDecide) begin
      mExp = mHeld; mWhy = "R7";
    end else if (r[own]) begin
      mExp = NM'(1) << own; mWhy = (mCyc == 0) ? "R2" : "R8";
    end else begin
      mExp = '0; mWhy = "R6";
      for (int k = 0; k < NM; k++) begin
        if (!mFallback && r[(mRr + k) % NM]) begin
          mFallback = 1'b1;
          mWin = (mRr + k) % NM;
          mExp = NM'(1) << mWin;
          mWhy = (mCyc == 0) ? "R3" : "R8";
        end
      end
    end
  endtask

  task automatic advance(input bit te, input int ti, input int to,
                         input bit ce, input int csl, input int cfl);
    bit slotEnd, frameEnd;
    if (mDecide && mFallback) mRr = (mWin + 1) % NM;
    mHeld = mExp;
    slotEnd  = (mCyc == mActSL);
    frameEnd = slotEnd && (mSlot == mActFL);
    mCyc = slotEnd ? 0 : mCyc + 1;
    if (frameEnd) begin
      mSlot = 0;
      for (int i = 0; i < SLOTS; i++) mAct[i] = mPend[i];
      mActSL = mPendSL;
      mActFL = mPendFL;
    end else if (slotEnd) begin
      mSlot = mSlot + 1;
    end
    if (te) mPend[ti] = to;
    if (ce) begin mPendSL = csl; mPendFL = cfl; end
  endtask

  task automatic step(input logic [NM-1:0] r, input bit te, input int ti, input int to,
                      input bit ce, input int csl, input int cfl, input string ph);
    @(negedge clk);
    req = r;
    tblWrEn = te; tblWrIdx = SLOT_W'(ti); tblWrOwner = MID_W'(to);
    cfgWrEn = ce; cfgSlotLast = LEN_W'(csl); cfgFrameLast = SLOT_W'(cfl);
    #1;
    computeExp(r);
    check(grant, mExp, {ph, "/", mWhy});
    if (ph == "R9") begin
      if (r[NM-1] && !grant[NM-1]) waitCnt++;
      else waitCnt = 0;
      if (waitCnt > maxWait) maxWait = waitCnt;
    end
    @(posedge clk);
    #1;
    advance(te, ti, to, ce, csl, cfl);
  endtask

  task automatic stepR(input logic [NM-1:0] r, input string ph);
    step(r, 1'b0, 0, 0, 1'b0, 0, 0, ph);
  endtask

  logic [NM-1:0] rnd = '0;
  task automatic nextRnd();
    if ($urandom_range(0, 2) == 0) rnd = NM'($urandom_range(0, NM'('1)));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    // R1: reset holds grant low
    repeat (3) begin
      @(negedge clk);
      #1;
      check(grant, '0, "R1 reset");
    end
    rstN = 1'b1;
    computeExp('0);
    @(posedge clk);
    #1;
    advance(1'b0, 0, 0, 1'b0, 0, 0);

    // R1: defaults; slot 0 owner 0 idle, fallback to master 2 from pointer 0
    repeat (3) stepR(4'b0100, "R1");
    // slot 1: owner 1 takes it, drops request, grant held (R7)
    stepR(4'b0010, "R1");
    repeat (3) stepR(4'b0000, "R7");
    // slot 2: nobody at start, master 3 arrives mid-slot (R8)
    stepR(4'b0000, "R8");
    repeat (3) stepR(4'b1000, "R8");
    // slot 3: owner 3 idle, pointer wrapped to 0, masters 1 and 2 ask
    repeat (4) stepR(4'b0110, "R3");

    // R2/R3: random contention on default frame
    repeat (400) begin nextRnd(); stepR(rnd, "R3"); end

    // R4: one-cycle slots, three-slot frame, then long slots
    step('0, 1'b0, 0, 0, 1'b1, 0, 2, "R4");
    repeat (300) begin nextRnd(); stepR(rnd, "R4"); end
    step('0, 1'b0, 0, 0, 1'b1, 6, 5, "R4");
    repeat (300) begin nextRnd(); stepR(rnd, "R4"); end

    // R5: master 2 takes every slot, written mid-frame
    for (int i = 0; i < SLOTS; i++) step(4'b1011, 1'b1, i, 2, 1'b0, 0, 0, "R5");
    repeat (300) begin nextRnd(); stepR(rnd, "R5"); end

    // restore defaults, then R9 starvation window
    step('0, 1'b0, 0, 0, 1'b1, SLOT_LAST_DEF, SLOTS - 1, "R5");
    for (int i = 0; i < SLOTS; i++) step(rnd, 1'b1, i, i % NM, 1'b0, 0, 0, "R5");
    repeat (120) begin nextRnd(); stepR(rnd, "R5"); end
    waitCnt = 0; maxWait = 0;
    repeat (600) begin nextRnd(); stepR(rnd | 4'b1000, "R9"); end
    nChecks++;
    if (maxWait > 2 * SLOTS * (SLOT_LAST_DEF + 1)) begin
      nFails++;
      $display("FAIL R9: longest wait=%0d expected<=%0d", maxWait, 2 * SLOTS * (SLOT_LAST_DEF + 1));
    end

    // mixed random with random table and frame-setting writes
    repeat (1500) begin
      bit te, ce;
      nextRnd();
      te = ($urandom_range(0, 19) == 0);
      ce = ($urandom_range(0, 39) == 0);
      step(rnd, te, $urandom_range(0, SLOTS - 1), $urandom_range(0, NM - 1),
           ce, $urandom_range(0, 5), $urandom_range(0, SLOTS - 1), "R5");
    end
    finishRun();
  end
endmodule